// File: doc/BRIEF.md
# Greedy Delay-Insertion Image Comparator

This block compares a known-good scan snapshot against the bits actually shifted out of a scan chain that may contain cells which go transparent during shifting. Each such cell drops one bit from the unloaded stream, so every bit captured nearer the scan-in end arrives one position later than expected. The engine walks the two images from the scan-out end toward the scan-in end. Each time the reference bit and the aligned observed bit disagree, it assumes one dropped bit at that position. It marks that position as a suspect and moves every later comparison one further place along the observed image.

A transparent cell anywhere inside a run of equal reference bits produces the same observed stream. For this reason, once the sweep ends, each suspect is spread over the run of equal reference bits that extends from it toward the scan-out end. The result is a suspect mask, a count of positions where the realigned images genuinely agree, and a one-cycle completion pulse. Position p (1 = scan-in end, N = scan-out end) maps to bit p-1 of every image and mask vector. Summing results over many image pairs is left to the consumer.

Top module: `delay_insert_cmp`

## Requirements
- R1: After reset, done_o, busy_o, cand_o and sim_o are all zero.
- R2: Positions are visited from N down to 1. Reference bit i is compared with observed bit i+k, where k is the number of mismatches found so far. An agreement leaves k unchanged and moves to position i-1.
- R3: A disagreement at position i (the observed bit not flagged don't-care) marks position i as a raw suspect and increments k by exactly one.
- R4: In cand_o, every raw suspect at i is extended to each position j>i for which all reference bits from i to j are equal. The extension stops at the first differing bit or at position N.
- R5: An observed bit whose obs_dc_i flag is 1 never causes a mismatch and is not counted in sim_o.
- R6: When done_o is high, sim_o equals the number of visited positions where the reference bit equals the aligned, non-don't-care observed bit.
- R7: done_o is high for exactly one cycle. It rises on the (N+1)-th rising edge after the edge that accepts start_i. busy_o is high from the accepting edge until that edge.
- R8: start_i is ignored while busy_o is high. The run in progress completes with its original images.
- R9: An accepted start_i captures all three image inputs and clears k, cand_o and sim_o on the accepting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a comparison when idle |
| ref_img_i | input | N | Fault-free reference image, bit p-1 = position p |
| obs_img_i | input | N | Observed failing image |
| obs_dc_i | input | N | Don't-care flag per observed bit |
| busy_o | output | 1 | Comparison in progress |
| done_o | output | 1 | One-cycle completion pulse |
| cand_o | output | N | Suspect mask after run widening |
| sim_o | output | $clog2(N+1) | Number of agreeing aligned positions |

## Verification
Identical images show that no suspect appears without a disagreement and that similarity reaches N. A worked 18-bit pair with two dropped bits separates correct realignment from a comparison without a shift, and checks run widening across runs of different length. A pair whose only suspect sits in a run that reaches the scan-out end tests where widening stops at position N. An all-don't-care observation shows that flagged bits neither cause insertions nor add similarity. A single modelled transparent cell and unconstrained random pairs are compared against an independent reference model. Restarts during a run and immediately after completion separate correct ignoring of start from correct clearing.

// File: rtl/dic_pkg.sv
package dic_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SWEEP = 2'd1,
    ST_WIDEN = 2'd2
  } dic_state_e;
endpackage

// File: rtl/dic_align.sv
module dic_align #(
  parameter int N  = 18,
  parameter int IW = $clog2(N),
  parameter int KW = $clog2(N + 1)
) (
  input  logic [N-1:0]  ref_img_i,
  input  logic [N-1:0]  obs_img_i,
  input  logic [N-1:0]  obs_dc_i,
  input  logic [IW-1:0] pos_i,
  input  logic [KW-1:0] shift_i,
  output logic          agree_o,
  output logic          mismatch_o
);
  localparam int AW = $clog2(2 * N + 1);

  logic [AW-1:0] idx;
  logic          ref_bit, obs_bit, obs_skip;

  assign idx = AW'(pos_i) + AW'(shift_i);

  always_comb begin
    ref_bit  = 1'b0;
    obs_bit  = 1'b0;
    obs_skip = 1'b1;  // aligned index past the chain end counts as don't-care
    for (int j = 0; j < N; j++) begin
      if (pos_i == IW'(j)) ref_bit = ref_img_i[j];
      if (idx == AW'(j)) begin
        obs_bit  = obs_img_i[j];
        obs_skip = obs_dc_i[j];
      end
    end
  end

  assign agree_o    = !obs_skip && (ref_bit == obs_bit);
  assign mismatch_o = !obs_skip && (ref_bit != obs_bit);
endmodule

// File: rtl/dic_widen.sv
module dic_widen #(
  parameter int N = 18
) (
  input  logic [N-1:0] raw_i,
  input  logic [N-1:0] ref_img_i,
  output logic [N-1:0] cand_o
);
  assign cand_o[0] = raw_i[0];

  for (genvar j = 1; j < N; j++) begin : g_chain
    // a suspect propagates toward scan-out while the reference bit repeats
    assign cand_o[j] = raw_i[j] | (cand_o[j-1] & ~(ref_img_i[j] ^ ref_img_i[j-1]));
  end
endmodule

// File: rtl/dic_sweep_ctrl.sv
module dic_sweep_ctrl
  import dic_pkg::*;
#(
  parameter int N  = 18,
  parameter int IW = $clog2(N),
  parameter int KW = $clog2(N + 1),
  parameter int SW = $clog2(N + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          agree_i,
  input  logic          mismatch_i,
  input  logic [N-1:0]  widened_i,
  output logic          load_o,
  output logic [IW-1:0] pos_o,
  output logic [KW-1:0] shift_o,
  output logic [N-1:0]  raw_o,
  output logic [N-1:0]  cand_o,
  output logic [SW-1:0] sim_o,
  output logic          busy_o,
  output logic          done_o
);
  localparam logic [IW-1:0] POS_TOP = IW'(N - 1);
  localparam logic [IW-1:0] IW_ONE  = IW'(1);
  localparam logic [KW-1:0] KW_ONE  = KW'(1);
  localparam logic [SW-1:0] SW_ONE  = SW'(1);
  localparam logic [SW-1:0] SIM_MAX = SW'(N);

  dic_state_e    state_q;
  logic [IW-1:0] pos_q;
  logic [KW-1:0] k_q;
  logic [N-1:0]  raw_q, cand_q;
  logic [SW-1:0] sim_q;
  logic          done_q;

  assign load_o = (state_q == ST_IDLE) && start_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      pos_q   <= '0;
      k_q     <= '0;
      raw_q   <= '0;
      cand_q  <= '0;
      sim_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            state_q <= ST_SWEEP;
            pos_q   <= POS_TOP;
            k_q     <= '0;
            raw_q   <= '0;
            cand_q  <= '0;
            sim_q   <= '0;
          end
        end
        ST_SWEEP: begin
          if (agree_i) sim_q <= sim_q + SW_ONE;
          if (mismatch_i) begin
            k_q <= k_q + KW_ONE;
            for (int j = 0; j < N; j++)
              if (pos_q == IW'(j)) raw_q[j] <= 1'b1;
          end
          if (pos_q == '0) state_q <= ST_WIDEN;
          else             pos_q   <= pos_q - IW_ONE;
        end
        ST_WIDEN: begin
          cand_q  <= widened_i;
          done_q  <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign pos_o   = pos_q;
  assign shift_o = k_q;
  assign raw_o   = raw_q;
  assign cand_o  = cand_q;
  assign sim_o   = sim_q;
  assign busy_o  = (state_q != ST_IDLE);
  assign done_o  = done_q;

  assert_done_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);

  assert_done_after_widen_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_q) |-> $past(state_q) == ST_WIDEN);

  assert_single_insert_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SWEEP) |=> (k_q == $past(k_q) || k_q == $past(k_q) + KW_ONE));

  assert_mark_on_mismatch_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SWEEP && mismatch_i) |=> $countones(raw_q) == $past($countones(raw_q)) + 1);

  assert_exclusive_compare_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SWEEP) |-> !(agree_i && mismatch_i));

  assert_busy_start_ignored_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SWEEP && start_i) |=> (state_q == ST_WIDEN || pos_q == $past(pos_q) - IW_ONE));

  assert_sim_bound_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> sim_q <= SIM_MAX);
endmodule

// File: rtl/delay_insert_cmp.sv
module delay_insert_cmp #(
  parameter int N  = 18,
  parameter int SW = $clog2(N + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [N-1:0]  ref_img_i,
  input  logic [N-1:0]  obs_img_i,
  input  logic [N-1:0]  obs_dc_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [N-1:0]  cand_o,
  output logic [SW-1:0] sim_o
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;
  localparam int KW = $clog2(N + 1);

  logic [N-1:0]  ref_q, obs_q, dc_q;
  logic          load, agree, mismatch;
  logic [IW-1:0] pos;
  logic [KW-1:0] shift;
  logic [N-1:0]  raw, widened;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ref_q <= '0;
      obs_q <= '0;
      dc_q  <= '0;
    end else if (load) begin
      ref_q <= ref_img_i;
      obs_q <= obs_img_i;
      dc_q  <= obs_dc_i;
    end
  end

  dic_align #(.N(N), .IW(IW), .KW(KW)) u_align (
    .ref_img_i (ref_q),
    .obs_img_i (obs_q),
    .obs_dc_i  (dc_q),
    .pos_i     (pos),
    .shift_i   (shift),
    .agree_o   (agree),
    .mismatch_o(mismatch)
  );

  dic_widen #(.N(N)) u_widen (
    .raw_i    (raw),
    .ref_img_i(ref_q),
    .cand_o   (widened)
  );

  dic_sweep_ctrl #(.N(N), .IW(IW), .KW(KW), .SW(SW)) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .agree_i   (agree),
    .mismatch_i(mismatch),
    .widened_i (widened),
    .load_o    (load),
    .pos_o     (pos),
    .shift_o   (shift),
    .raw_o     (raw),
    .cand_o    (cand_o),
    .sim_o     (sim_o),
    .busy_o    (busy_o),
    .done_o    (done_o)
  );

  assert_images_held_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o) |=> $stable(ref_q) && $stable(obs_q) && $stable(dc_q));
endmodule

// File: tb/delay_insert_cmp_tb_top.sv
`timescale 1ns/1ps
module delay_insert_cmp_tb_top;
  localparam int N  = 18;
  localparam int SW = $clog2(N + 1);

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          start = 1'b0;
  logic [N-1:0]  ref_img = '0, obs_img = '0, obs_dc = '0;
  logic          busy, done;
  logic [N-1:0]  cand;
  logic [SW-1:0] sim;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  delay_insert_cmp #(.N(N)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start),
    .ref_img_i(ref_img), .obs_img_i(obs_img), .obs_dc_i(obs_dc),
    .busy_o(busy), .done_o(done), .cand_o(cand), .sim_o(sim)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected<150000", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Independent model: 1-based walk from the scan-out end, then run spread.
  task automatic model(input logic [N-1:0] g, input logic [N-1:0] f, input logic [N-1:0] dc,
                       output logic [N-1:0] exp_cand, output int exp_sim);
    int k;
    logic [N-1:0] raw;
    k = 0; raw = '0; exp_sim = 0;
    for (int i = N; i >= 1; i--) begin
      int a;
      a = i + k;
      if (a <= N && !dc[a-1]) begin
        if (g[i-1] == f[a-1]) exp_sim++;
        else begin raw[i-1] = 1'b1; k++; end
      end
    end
    exp_cand = raw;
    for (int i = 1; i <= N; i++) begin
      if (raw[i-1]) begin
        for (int j = i + 1; j <= N; j++) begin
          if (g[j-1] != g[i-1]) break;
          exp_cand[j-1] = 1'b1;
        end
      end
    end
  endtask

  // Drives start on a falling edge, returns results and latency in falling edges.
  task automatic run_pair(input logic [N-1:0] g, input logic [N-1:0] f, input logic [N-1:0] dc,
                          output int lat, output logic busy_first, output logic done_after);
    @(negedge clk);
    ref_img = g; obs_img = f; obs_dc = dc; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    busy_first = busy;
    lat = 1;
    while (!done && lat < 1000) begin
      @(negedge clk);
      lat++;
    end
    @(negedge clk);
    done_after = done;
    @(posedge clk);
    #1;
  endtask

  task automatic run_and_compare(input string req, input logic [N-1:0] g,
                                 input logic [N-1:0] f, input logic [N-1:0] dc);
    logic [N-1:0] ec;
    int es, lat;
    logic b, d;
    model(g, f, dc, ec, es);
    @(negedge clk);
    ref_img = g; obs_img = f; obs_dc = dc; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!done && lat < 1000) begin @(negedge clk); lat++; end
    chk(req, "cand", 32'(cand), 32'(ec));
    chk(req, "sim", 32'(sim), 32'(es));
    b = busy; d = done;
  endtask

  task automatic t_reset;
    chk("R1", "done", 32'(done), 0);
    chk("R1", "busy", 32'(busy), 0);
    chk("R1", "cand", 32'(cand), 0);
    chk("R1", "sim", 32'(sim), 0);
  endtask

  task automatic t_identical;
    logic [N-1:0] g = 18'b110100111000101101;
    run_and_compare("R2", g, g, '0);
    chk("R2", "identical cand", 32'(cand), 0);
    chk("R6", "identical sim", 32'(sim), N);
  endtask

  task automatic t_example;
    // positions 18..1, left to right
    logic [N-1:0] g  = 18'b101010001111001101;
    logic [N-1:0] f  = 18'b101010011110110100;
    logic [N-1:0] dc = 18'b000000000000000011;
    run_and_compare("R3", g, f, dc);
    chk("R4", "example cand {5,6,11,12,13}", 32'(cand), 32'(18'b000001110000110000));
    chk("R6", "example sim", 32'(sim), 16);
  endtask

  task automatic t_top_run;
    logic [N-1:0] g = 18'b111100000000000000;
    logic [N-1:0] f = 18'b111000000000000000;
    run_and_compare("R4", g, f, '0);
    chk("R4", "widen to position N", 32'(cand), 32'(18'b111100000000000000));
    chk("R6", "top run sim", 32'(sim), 17);
  endtask

  task automatic t_dont_care;
    logic [N-1:0] g = 18'b010101010101010101;
    logic [N-1:0] f = ~g;
    run_and_compare("R5", g, f, '1);
    chk("R5", "all dc cand", 32'(cand), 0);
    chk("R5", "all dc sim", 32'(sim), 0);
  endtask

  task automatic t_latency;
    int lat;
    logic b, d;
    run_pair(18'h2a5a5, 18'h15a5a, '0, lat, b, d);
    chk("R7", "busy after start", 32'(b), 1);
    chk("R7", "done latency", 32'(lat), N + 2);
    chk("R7", "done single cycle", 32'(d), 0);
    chk("R7", "idle after done", 32'(busy), 0);
  endtask

  task automatic t_restart_clear;
    // previous run left candidates; a new start must clear outputs at once
    logic [N-1:0] g = 18'b101010001111001101;
    logic [N-1:0] f = 18'b101010011110110100;
    run_and_compare("R9", g, f, 18'b11);
    @(negedge clk);
    ref_img = g; obs_img = g; obs_dc = '0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R9", "cand cleared", 32'(cand), 0);
    chk("R9", "sim cleared", 32'(sim), 0);
    while (!done) @(negedge clk);
    chk("R9", "fresh cand", 32'(cand), 0);
    chk("R9", "fresh sim", 32'(sim), N);
  endtask

  task automatic t_busy_start;
    logic [N-1:0] g = 18'b001110010110100011;
    logic [N-1:0] f = 18'b011100101101000110;
    logic [N-1:0] ec;
    int es;
    model(g, f, '0, ec, es);
    @(negedge clk);
    ref_img = g; obs_img = f; obs_dc = '0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (4) @(negedge clk);
    ref_img = ~g; obs_img = g; obs_dc = 18'h3; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done) @(negedge clk);
    chk("R8", "cand of first run", 32'(cand), 32'(ec));
    chk("R8", "sim of first run", 32'(sim), 32'(es));
    @(negedge clk);
    chk("R8", "no second run", 32'(busy), 0);
  endtask

  task automatic t_hold_fault;
    for (int t = 0; t < 6; t++) begin
      logic [N-1:0] g, f, dc;
      int p;
      g = N'($urandom);
      p = 2 + (t * 3) % (N - 1);
      f = '0; dc = '0;
      for (int j = 1; j <= N; j++) begin
        if (j > p)       f[j-1] = g[j-1];
        else if (j >= 2) f[j-1] = g[j-2];
        else             dc[0]  = 1'b1;
      end
      run_and_compare("R2", g, f, dc);
      checks++;
      if (!cand[p-1]) begin
        errors++;
        $display("FAIL R3 fault position %0d not marked actual=%0h expected bit set", p, cand);
      end
    end
  endtask

  task automatic t_random;
    for (int t = 0; t < 10; t++) begin
      logic [N-1:0] g, f, dc;
      g  = N'($urandom);
      f  = N'($urandom);
      dc = N'($urandom) & N'($urandom) & N'($urandom);
      run_and_compare("R6", g, f, dc);
    end
  endtask

  initial begin
    void'($urandom(13));
    repeat (3) @(negedge clk);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_identical();
    t_example();
    t_top_run();
    t_dont_care();
    t_latency();
    t_restart_clear();
    t_busy_start();
    t_hold_fault();
    t_random();
    repeat (2) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule